// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block holds the single atomic reservation of one hardware thread. It is what makes a load-linked / store-conditional pair work. A load-linked request records the 16-byte granule of its physical address and arms a valid flag. A later store-conditional is judged against that armed granule. A matching store is sent on to memory and reports success. A store that does not match is failed locally: it never reaches memory and returns a failure code together with the reason it failed.

Conditional stores to uncacheable space skip the check altogether. They are always sent on, with a distinct code that tells the pipeline to leave the destination register untouched. A snoop hit on the reserved granule, or an exception return, drives an invalidate input that disarms the reservation. Failures that follow one another are counted. When the count reaches a fixed limit, a livelock alarm is raised and held.

The request side carries the request kind, the physical address and an uncacheable bit. Only one request is in flight at a time: each accepted request gets exactly one registered response on the next cycle.

Top module: `resv_monitor`

## Requirements
- R1: A synchronous active-high reset disarms the reservation, clears the stored granule, the failure count and the alarm, and drops rsp_valid, so that req_ready is 1 after reset.
- R2: A load-linked request (req_kind = 0) stores req_paddr with its 4 low bits dropped as the reservation granule and arms the flag. Its response is rsp_issue = 1, rsp_code = 3, rsp_cause = 0.
- R3: A cacheable store-conditional (req_kind = 1, req_uncached = 0) passes when the flag is armed and its granule equals the stored one; the 4 low address bits play no part. It then responds rsp_issue = 1, rsp_code = 1, rsp_cause = 0, disarms the flag, zeroes the failure count and clears the alarm.
- R4: A failing cacheable store-conditional responds rsp_issue = 0, rsp_code = 0 and disarms the flag. rsp_cause is 2'b01 when the flag was not armed. It is 2'b10 when the flag was armed but the granule differed. The 2'b01 case takes priority.
- R5: An uncacheable store-conditional responds rsp_issue = 1, rsp_code = 2, rsp_cause = 0, whatever the reservation holds. It leaves the flag, the granule, the count and the alarm unchanged.
- R6: snoop_inv disarms the flag at the next clock edge. A request accepted in the same cycle sees the flag as disarmed: a store-conditional fails with cause 2'b01, and a load-linked records its granule but leaves the flag disarmed.
- R7: A request is accepted when req_valid and req_ready are both 1. rsp_valid is 1 for exactly the one cycle after acceptance, and req_ready is 0 during that cycle.
- R8: Each failing cacheable store-conditional raises the failure count by one. The count saturates at FAIL_LIMIT (default 5000). The alarm rises together with the response of the failure that brings the count to FAIL_LIMIT, and stays high until a passing store-conditional or a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 1 | 0 = load-linked, 1 = store-conditional |
| req_paddr | input | PA_W | Physical address of the request |
| req_uncached | input | 1 | Request targets uncacheable space |
| snoop_inv | input | 1 | Disarm the reservation (snoop hit or exception return) |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | Response present |
| rsp_issue | output | 1 | Forward the access to memory |
| rsp_code | output | 2 | 0 fail, 1 success, 2 no register write, 3 load-linked |
| rsp_cause | output | 2 | Failure reason: 01 flag clear, 10 granule mismatch |
| livelock_alarm | output | 1 | Failure count reached FAIL_LIMIT |

## Verification
The risky overlap is an invalidate that lands in the same cycle as an accepted request. The invalidate must win over both the check of a store-conditional and the arming by a load-linked. The bench provokes this directly: it raises snoop_inv together with a store-conditional to the armed granule, and together with a load-linked. It then judges the response code and cause, and tests the resulting flag with a follow-up store-conditional. Random traffic also sets snoop_inv alongside requests, and a bench reference model predicts every response.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic {
    REQ_LOAD_LINK  = 1'b0,
    REQ_STORE_COND = 1'b1
  } req_kind_e;

  typedef enum logic [1:0] {
    CODE_FAIL = 2'd0,
    CODE_OK   = 2'd1,
    CODE_NOWB = 2'd2,
    CODE_LL   = 2'd3
  } rsp_code_e;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_NOFLAG   = 2'b01,
    CAUSE_MISMATCH = 2'b10
  } fail_cause_e;

  typedef struct packed {
    logic       issue;
    logic [1:0] code;
    logic [1:0] cause;
    logic       failed;
    logic       passed;
  } verdict_t;

endpackage

// File: rtl/resv_store.sv
module resv_store #(
  parameter int GW = 28
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inv,
  input  logic          set,
  input  logic          drop,
  input  logic [GW-1:0] gran_in,
  output logic          flag_q,
  output logic [GW-1:0] gran_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      gran_q <= '0;
    end else begin
      if (set) gran_q <= gran_in;
      if (inv)       flag_q <= 1'b0;
      else if (set)  flag_q <= 1'b1;
      else if (drop) flag_q <= 1'b0;
    end
  end

endmodule

// File: rtl/resv_judge.sv
module resv_judge
  import resv_pkg::*;
#(
  parameter int GW = 28
) (
  input  logic          is_sc,
  input  logic          uncached,
  input  logic          flag_eff,
  input  logic [GW-1:0] held_gran,
  input  logic [GW-1:0] req_gran,
  output verdict_t      v
);

  always_comb begin
    v = '0;
    if (!is_sc) begin
      v.issue = 1'b1;
      v.code  = CODE_LL;
    end else if (uncached) begin
      v.issue = 1'b1;
      v.code  = CODE_NOWB;
    end else if (!flag_eff) begin
      v.code   = CODE_FAIL;
      v.cause  = CAUSE_NOFLAG;
      v.failed = 1'b1;
    end else if (held_gran != req_gran) begin
      v.code   = CODE_FAIL;
      v.cause  = CAUSE_MISMATCH;
      v.failed = 1'b1;
    end else begin
      v.issue  = 1'b1;
      v.code   = CODE_OK;
      v.passed = 1'b1;
    end
  end

endmodule

// File: rtl/fail_counter.sv
module fail_counter #(
  parameter int LIMIT = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic bump,
  input  logic clear,
  output logic alarm_q
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);
  localparam logic [CW-1:0] TOP_M1 = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      alarm_q <= 1'b0;
    end else if (clear) begin
      cnt_q   <= '0;
      alarm_q <= 1'b0;
    end else if (bump) begin
      if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
      if (cnt_q >= TOP_M1) alarm_q <= 1'b1;
    end
  end

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int PA_W       = 32,
  parameter int GRAN_LSB   = 4,
  parameter int FAIL_LIMIT = 5000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_kind,
  input  logic [PA_W-1:0] req_paddr,
  input  logic            req_uncached,
  input  logic            snoop_inv,
  output logic            req_ready,
  output logic            rsp_valid,
  output logic            rsp_issue,
  output logic [1:0]      rsp_code,
  output logic [1:0]      rsp_cause,
  output logic            livelock_alarm
);

  localparam int GW = PA_W - GRAN_LSB;

  logic          accept;
  logic          is_sc;
  logic          flag_q;
  logic [GW-1:0] gran_q;
  logic [GW-1:0] req_gran;
  logic          unused_low;
  verdict_t      v;

  assign req_ready  = ~rsp_valid;
  assign accept     = req_valid & req_ready;
  assign is_sc      = (req_kind == REQ_STORE_COND);
  assign req_gran   = req_paddr[PA_W-1:GRAN_LSB];
  assign unused_low = ^req_paddr[GRAN_LSB-1:0];

  resv_store #(.GW(GW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .inv     (snoop_inv),
    .set     (accept & ~is_sc),
    .drop    (accept & is_sc & ~req_uncached),
    .gran_in (req_gran),
    .flag_q  (flag_q),
    .gran_q  (gran_q)
  );

  resv_judge #(.GW(GW)) u_judge (
    .is_sc     (is_sc),
    .uncached  (req_uncached),
    .flag_eff  (flag_q & ~snoop_inv),
    .held_gran (gran_q),
    .req_gran  (req_gran),
    .v         (v)
  );

  fail_counter #(.LIMIT(FAIL_LIMIT)) u_count (
    .clk     (clk),
    .rst     (rst),
    .bump    (accept & v.failed),
    .clear   (accept & v.passed),
    .alarm_q (livelock_alarm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_issue <= 1'b0;
      rsp_code  <= 2'd0;
      rsp_cause <= 2'd0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_issue <= v.issue;
        rsp_code  <= v.code;
        rsp_cause <= v.cause;
      end
    end
  end

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_issue,
  input logic [1:0] rsp_code,
  input logic [1:0] rsp_cause,
  input logic       livelock_alarm
);

  // R7
  one_rsp_per_accept_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready));

  // R7
  single_cycle_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R4
  fail_form_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_issue) |-> (rsp_code == 2'd0 && rsp_cause != 2'd0));

  // R4
  cause_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rsp_cause));

  // R5
  nowb_issues_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == 2'd2) |-> (rsp_issue && rsp_cause == 2'd0));

  // R8
  alarm_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(livelock_alarm) |-> (rsp_valid && rsp_code == 2'd0));

  // R8
  alarm_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(livelock_alarm)) |-> (rsp_valid && rsp_code == 2'd1));

endmodule

bind resv_monitor resv_monitor_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .rsp_valid      (rsp_valid),
  .rsp_issue      (rsp_issue),
  .rsp_code       (rsp_code),
  .rsp_cause      (rsp_cause),
  .livelock_alarm (livelock_alarm)
);

// File: tb/test_resv_monitor.sv
module test_resv_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 32;
  localparam int LIMIT = 5000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic            req_kind = 1'b0;
  logic [PA_W-1:0] req_paddr = '0;
  logic            req_uncached = 1'b0;
  logic            snoop_inv = 1'b0;
  logic            req_ready, rsp_valid, rsp_issue, livelock_alarm;
  logic [1:0]      rsp_code, rsp_cause;

  resv_monitor #(.PA_W(PA_W), .GRAN_LSB(4), .FAIL_LIMIT(LIMIT)) i_resv_monitor (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_paddr(req_paddr), .req_uncached(req_uncached), .snoop_inv(snoop_inv),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_issue(rsp_issue),
    .rsp_code(rsp_code), .rsp_cause(rsp_cause), .livelock_alarm(livelock_alarm)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  bit              m_flag;
  logic [PA_W-5:0] m_gran;
  int              m_cnt;
  bit              m_alarm;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // {issue, code[1:0], cause[1:0]}
  function automatic logic [4:0] exp_rsp(bit sc, bit unc, bit inv, logic [PA_W-1:0] a);
    bit fl = m_flag && !inv;
    if (!sc) return {1'b1, 2'd3, 2'b00};
    if (unc) return {1'b1, 2'd2, 2'b00};
    if (!fl) return {1'b0, 2'd0, 2'b01};
    if (a[PA_W-1:4] != m_gran) return {1'b0, 2'd0, 2'b10};
    return {1'b1, 2'd1, 2'b00};
  endfunction

  task automatic model_update(bit sc, bit unc, bit inv, logic [PA_W-1:0] a, logic [4:0] e);
    if (!sc) begin
      m_gran = a[PA_W-1:4];
      m_flag = 1'b1;
    end else if (!unc) begin
      if (e[3:2] == 2'd1) begin
        m_cnt = 0;
        m_alarm = 0;
      end else begin
        if (m_cnt < LIMIT) m_cnt++;
        if (m_cnt == LIMIT) m_alarm = 1;
      end
      m_flag = 1'b0;
    end
    if (inv) m_flag = 1'b0;
  endtask

  task automatic issue_req(bit sc, bit unc, bit inv, logic [PA_W-1:0] a, string tag);
    logic [4:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_kind = sc; req_paddr = a; req_uncached = unc; snoop_inv = inv;
    e = exp_rsp(sc, unc, inv, a);
    model_update(sc, unc, inv, a, e);
    @(posedge clk); #1;
    chk(tag, rsp_valid, 1, "rsp_valid");
    chk(tag, {rsp_issue, rsp_code, rsp_cause}, e, "issue/code/cause");
    chk(tag, livelock_alarm, m_alarm, "alarm");
    chk("R7", req_ready, 0, "req_ready while pending");
    @(negedge clk);
    req_valid = 1'b0; snoop_inv = 1'b0;
    @(posedge clk); #1;
    chk("R7", rsp_valid, 0, "rsp_valid after one cycle");
  endtask

  task automatic idle_inv();
    @(negedge clk); snoop_inv = 1'b1;
    @(negedge clk); snoop_inv = 1'b0;
    m_flag = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; req_valid = 1'b0; snoop_inv = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 1'b0;
    m_flag = 0; m_gran = '0; m_cnt = 0; m_alarm = 0;
    #1;
    chk("R1", rsp_valid, 0, "rsp_valid after reset");
    chk("R1", req_ready, 1, "req_ready after reset");
    chk("R1", livelock_alarm, 0, "alarm after reset");
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();

    // R2 / R3: low bits ignored in the match
    issue_req(0, 0, 0, 32'h1234, "R2");
    issue_req(1, 0, 0, 32'h123C, "R3");
    issue_req(1, 0, 0, 32'h1230, "R4");   // flag dropped by the pass
    // R4 mismatch then flag-clear
    issue_req(0, 0, 0, 32'h1000, "R2");
    issue_req(1, 0, 0, 32'h1010, "R4");
    issue_req(1, 0, 0, 32'h1000, "R4");
    // R5: uncached leaves the reservation intact
    issue_req(0, 0, 0, 32'h2000, "R2");
    issue_req(1, 1, 0, 32'h5000, "R5");
    issue_req(1, 0, 0, 32'h2004, "R5");
    // R6: idle invalidate, same-cycle SC, same-cycle LL
    issue_req(0, 0, 0, 32'h3000, "R2");
    idle_inv();
    issue_req(1, 0, 0, 32'h3000, "R6");
    issue_req(0, 0, 0, 32'h3000, "R2");
    issue_req(1, 0, 1, 32'h3000, "R6");
    issue_req(0, 0, 1, 32'h3000, "R6");
    issue_req(1, 0, 0, 32'h3000, "R6");
    // R8: count to the limit
    issue_req(0, 0, 0, 32'h4000, "R2");
    issue_req(1, 0, 0, 32'h4000, "R3");
    for (int i = 0; i < LIMIT - 1; i++) issue_req(1, 0, 0, 32'h4000, "R8");
    chk("R8", livelock_alarm, 0, "alarm one short of limit");
    issue_req(1, 0, 0, 32'h4000, "R8");
    chk("R8", livelock_alarm, 1, "alarm at limit");
    issue_req(1, 0, 0, 32'h4000, "R8");
    issue_req(1, 1, 0, 32'h4000, "R5");
    chk("R5", livelock_alarm, 1, "alarm kept by uncached SC");
    issue_req(0, 0, 0, 32'h4000, "R2");
    issue_req(1, 0, 0, 32'h4008, "R8");
    chk("R8", livelock_alarm, 0, "alarm cleared by pass");
    // R1: reset drops a live reservation
    issue_req(0, 0, 0, 32'h6000, "R2");
    do_reset();
    issue_req(1, 0, 0, 32'h6000, "R1");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      bit sc = $urandom_range(0, 1);
      bit unc = ($urandom_range(0, 7) == 0);
      bit inv = ($urandom_range(0, 5) == 0);
      logic [PA_W-1:0] a = {26'h0, 2'($urandom_range(0, 3)), 4'($urandom)};
      logic [4:0] e = exp_rsp(sc, unc, inv, a);
      string tag = inv ? "R6" : !sc ? "R2" : unc ? "R5" : (e[4] ? "R3" : "R4");
      issue_req(sc, unc, inv, a, tag);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule